// File: doc/BRIEF.md
# Single-Clock FIFO with Threshold and Error Flags

This block is a first-in first-out buffer in which writes and reads share one clock. Storage is an inferred memory array. Its depth is not set directly: it follows from the data width and a memory-size parameter, and the narrowest words get the deepest buffer.

The write side is a valid/ready stream. `wr_ready` is high whenever the buffer is not full. A word is taken on any rising edge where `wr_valid` and `wr_ready` are both high. If `wr_valid` is raised while `wr_ready` is low, the word is dropped and a write-error pulse follows. The producer is expected to hold `wr_valid` until it sees `wr_ready`.

The read side has no back-pressure. The consumer raises `rd_en` to pull a word. `rd_valid` marks each cycle in which `rd_data` carries a newly read word. The status outputs are plain levels: empty, full, the two threshold flags, the two error pulses, and the raw read and write pointers. An optional output register adds one cycle of read latency and in return shortens the clock-to-out path.

Top module: `sync_fifo_flags`

## Requirements
- R1: Depth follows the data width and the memory-size parameter `BIG_MEM`.
  - With `BIG_MEM`=1, the depth is 512 for widths 37..72, 1024 for 19..36, 2048 for 10..18, 4096 for 5..9 and 8192 for 1..4.
  - With `BIG_MEM`=0, each of these depths is halved, and widths above 36 are not allowed.
  - `full` goes high exactly when the buffer holds depth words.
- R2: An active-low `rst_n` acts asynchronously, without waiting for a clock edge. It zeroes both pointers, so `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `rd_valid`=0 and both error flags are 0.
- R3: A write request (`wr_valid`=1) while `full` is set:
  - the word is discarded;
  - `wr_count` does not move;
  - `wr_err` is 1 after the next edge.
  - `wr_ready` is always the inverse of `full`.
- R4: A read request (`rd_en`=1) while `empty` is set:
  - `rd_count` and the stored words are left as they are;
  - no `rd_valid` is produced;
  - `rd_err` is 1 after the next edge.
- R5: `almost_empty` is 1 exactly when the occupancy is less than or equal to `AE_OFFSET`.
- R6: `almost_full` is 1 exactly when the free space (depth minus occupancy) is less than or equal to `AF_OFFSET`.
- R7: Read latency depends on `OUT_REG`:
  - With `OUT_REG`=0, an accepted read shows `rd_valid`=1 and its word on `rd_data` right after the edge that accepts it.
  - With `OUT_REG`=1, both appear one edge later.
  - `rd_data` holds its value between reads.
- R8: `wr_count` and `rd_count` are the write and read pointers. They are log2(depth) bits wide, each advances by one per accepted access, and each wraps modulo the depth.
- R9: A write and a read in the same cycle, on a buffer that is neither empty nor full, both complete. Both pointers advance and the occupancy stays the same.
- R10: Words leave in the order in which they were accepted.
- R11: `wr_err` and `rd_err` are not sticky. Each is 0 after any edge at which no offending request was present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request / word valid |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | Buffer can take a word |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | `rd_data` carries a newly read word |
| rd_data | output | DATA_W | Word read out |
| empty | output | 1 | No words stored |
| full | output | 1 | Every entry holds a word |
| almost_empty | output | 1 | Occupancy at or below `AE_OFFSET` |
| almost_full | output | 1 | Free space at or below `AF_OFFSET` |
| wr_err | output | 1 | Pulse: write was requested while full |
| rd_err | output | 1 | Pulse: read was requested while empty |
| wr_count | output | PTR_W | Write pointer |
| rd_count | output | PTR_W | Read pointer |

## Verification
The occupancy counter drives every flag. A stuck or misstepping counter therefore shows on `empty`, `almost_empty`, `almost_full` or `full` at the very next edge after the first wrong access, as long as the occupancy is near a threshold; the bench walks the occupancy through both thresholds and up to both ends. A pointer that slips shows at once on `wr_count` or `rd_count`, and it also shows as out-of-order data on the next read of the affected entry. A wrong latency or a missing output stage shows on `rd_valid` in the first cycle after an accepted read. The bench checks this on two instances that differ only in `OUT_REG`.

// File: rtl/fifo_cfg_pkg.sv
package fifo_cfg_pkg;

  // Depth picked from word width; the small memory setting halves it.
  function automatic int depth_for(input int width, input bit big_mem);
    int d;
    if (width > 36)      d = 512;
    else if (width > 18) d = 1024;
    else if (width > 9)  d = 2048;
    else if (width > 4)  d = 4096;
    else                 d = 8192;
    return big_mem ? d : d / 2;
  endfunction

  // Accepted operations for the current cycle.
  typedef struct packed {
    logic wr_acc;
    logic rd_acc;
  } fifo_op_t;

endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int DEPTH  = 512,
  parameter int PTR_W  = 9,
  parameter int AE_OFF = 4,
  parameter int AF_OFF = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic                  rd_req,
  output fifo_cfg_pkg::fifo_op_t op,
  output logic [PTR_W-1:0]      wr_ptr,
  output logic [PTR_W-1:0]      rd_ptr,
  output logic                  empty,
  output logic                  full,
  output logic                  almost_empty,
  output logic                  almost_full,
  output logic                  wr_err,
  output logic                  rd_err
);
  localparam int CNT_W = PTR_W + 1;

  logic [CNT_W-1:0] occ;

  always_comb begin
    empty        = (occ == '0);
    full         = (occ == CNT_W'(DEPTH));
    almost_empty = (int'(occ) <= AE_OFF);
    almost_full  = ((DEPTH - int'(occ)) <= AF_OFF);
    op.wr_acc    = wr_req & ~full;
    op.rd_acc    = rd_req & ~empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      wr_err <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      if (op.wr_acc) wr_ptr <= wr_ptr + PTR_W'(1);
      if (op.rd_acc) rd_ptr <= rd_ptr + PTR_W'(1);
      case ({op.wr_acc, op.rd_acc})
        2'b10:   occ <= occ + CNT_W'(1);
        2'b01:   occ <= occ - CNT_W'(1);
        default: occ <= occ;
      endcase
      wr_err <= wr_req & full;
      rd_err <= rd_req & empty;
    end
  end

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512,
  parameter int PTR_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage #(
  parameter int DATA_W  = 36,
  parameter int OUT_REG = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  generate
    if (OUT_REG != 0) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_data  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_data <= in_data;
        end
      end
    end else begin : g_pass
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/sync_fifo_flags.sv
module sync_fifo_flags #(
  parameter int DATA_W    = 36,
  parameter bit BIG_MEM   = 1'b0,
  parameter int AE_OFFSET = 4,
  parameter int AF_OFFSET = 4,
  parameter int OUT_REG   = 0,
  localparam int DEPTH    = fifo_cfg_pkg::depth_for(DATA_W, BIG_MEM),
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              wr_err,
  output logic              rd_err,
  output logic [PTR_W-1:0]  wr_count,
  output logic [PTR_W-1:0]  rd_count
);
  fifo_cfg_pkg::fifo_op_t op;
  logic [DATA_W-1:0]      mem_q;
  logic                   mem_v;

  fifo_ctrl #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .AE_OFF(AE_OFFSET), .AF_OFF(AF_OFFSET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_valid), .rd_req(rd_en), .op(op),
    .wr_ptr(wr_count), .rd_ptr(rd_count), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .wr_err(wr_err), .rd_err(rd_err)
  );

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(op.wr_acc), .wr_addr(wr_count),
    .wr_data(wr_data), .rd_en(op.rd_acc), .rd_addr(rd_count),
    .rd_data(mem_q), .rd_valid(mem_v)
  );

  fifo_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(mem_v), .in_data(mem_q),
    .out_valid(rd_valid), .out_data(rd_data)
  );

  assign wr_ready = ~full;

endmodule

// File: rtl/sync_fifo_flags_chk.sv
module sync_fifo_flags_chk #(
  parameter int PTR_W   = 9,
  parameter int OUT_REG = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             empty,
  input logic             full,
  input logic             almost_empty,
  input logic             wr_err,
  input logic             rd_err,
  input logic [PTR_W-1:0] wr_count,
  input logic [PTR_W-1:0] rd_count
);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && full |=> wr_err && $stable(wr_count));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty |=> rd_err && $stable(rd_count));

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && empty) |=> !rd_err);

  p_wr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !full |=> wr_count == $past(wr_count) + PTR_W'(1));

  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rd_en && !empty && !full |=> $stable(empty) && $stable(full));

  p_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  p_ae_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty);

  generate
    if (OUT_REG != 0) begin : g_lat2
      p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !empty |=> ##1 rd_valid);
    end else begin : g_lat1
      p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !empty |=> rd_valid);
    end
  endgenerate

endmodule

bind sync_fifo_flags sync_fifo_flags_chk #(.PTR_W(PTR_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en),
  .rd_valid(rd_valid), .empty(empty), .full(full), .almost_empty(almost_empty),
  .wr_err(wr_err), .rd_err(rd_err), .wr_count(wr_count), .rd_count(rd_count)
);

// File: tb/sync_fifo_flags_tb_top.sv
module sync_fifo_flags_tb_top;
  localparam int CLK_NS = 10;
  localparam int DW     = 36;
  localparam int DEPTH  = 512;   // R1: width 36, small memory
  localparam int PW     = 9;
  localparam int AE     = 4;
  localparam int AF     = 4;

  // vector: {wr, rd, exp_empty, exp_almost_empty, exp_rd_err}
  localparam logic [4:0] VECS [13] = '{
    5'b01_111, 5'b10_010, 5'b10_010, 5'b10_010, 5'b10_010,
    5'b10_000, 5'b11_000, 5'b01_010, 5'b01_010, 5'b01_010,
    5'b01_010, 5'b01_110, 5'b01_111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, empty, full, almost_empty, almost_full, wr_err, rd_err;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] wr_count, rd_count;
  logic wr_ready2, rd_valid2, empty2, full2, ae2, af2, wr_err2, rd_err2;
  logic [DW-1:0] rd_data2;
  logic [PW-1:0] wr_count2, rd_count2;

  int total = 0;
  int bad = 0;
  int occ = 0;
  int wptr = 0;
  int rptr = 0;
  int dseq = 0;
  logic [DW-1:0] q[$];
  bit pend2 = 1'b0;
  logic [DW-1:0] pend2_d = '0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sync_fifo_flags #(.DATA_W(DW), .BIG_MEM(1'b0), .AE_OFFSET(AE), .AF_OFFSET(AF),
    .OUT_REG(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .empty(empty), .full(full), .almost_empty(almost_empty),
    .almost_full(almost_full), .wr_err(wr_err), .rd_err(rd_err),
    .wr_count(wr_count), .rd_count(rd_count));

  sync_fifo_flags #(.DATA_W(DW), .BIG_MEM(1'b0), .AE_OFFSET(AE), .AF_OFFSET(AF),
    .OUT_REG(1)) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready2), .rd_en(rd_en), .rd_valid(rd_valid2), .rd_data(rd_data2),
    .empty(empty2), .full(full2), .almost_empty(ae2),
    .almost_full(af2), .wr_err(wr_err2), .rd_err(rd_err2),
    .wr_count(wr_count2), .rd_count(rd_count2));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_model();
    occ = 0; wptr = 0; rptr = 0; q.delete(); pend2 = 1'b0;
  endtask

  // One cycle: called at a falling edge, returns at the next falling edge.
  task automatic cyc(input bit wr, input bit rd);
    bit wa, ra, errw, errr;
    logic [DW-1:0] d, exp_d;
    exp_d = '0;
    d = {4'hC, 32'(dseq)};
    dseq++;
    wr_valid = wr; rd_en = rd; wr_data = d;
    wa = wr && (occ < DEPTH);
    ra = rd && (occ > 0);
    errw = wr && (occ == DEPTH);
    errr = rd && (occ == 0);
    if (ra) exp_d = q.pop_front();
    if (wa) q.push_back(d);
    @(posedge clk);
    #(CLK_NS/4);
    if (wa) wptr = (wptr + 1) % DEPTH;
    if (ra) rptr = (rptr + 1) % DEPTH;
    occ = occ + int'(wa) - int'(ra);
    chk(64'(full), 64'(occ == DEPTH), "R1 full");
    chk(64'(wr_ready), 64'(occ != DEPTH), "R3 wr_ready");
    chk(64'(empty), 64'(occ == 0), "R4 empty");
    chk(64'(almost_empty), 64'(occ <= AE), "R5 almost_empty");
    chk(64'(almost_full), 64'((DEPTH - occ) <= AF), "R6 almost_full");
    chk(64'(wr_err), 64'(errw), errw ? "R3 wr_err" : "R11 wr_err quiet");
    chk(64'(rd_err), 64'(errr), errr ? "R4 rd_err" : "R11 rd_err quiet");
    chk(64'(wr_count), 64'(wptr), "R8 wr_count");
    chk(64'(rd_count), 64'(rptr), "R8 rd_count");
    chk(64'(rd_valid), 64'(ra), "R7 rd_valid no out reg");
    if (ra) chk(64'(rd_data), 64'(exp_d), "R10 order");
    chk(64'(rd_valid2), 64'(pend2), "R7 rd_valid with out reg");
    if (pend2) chk(64'(rd_data2), 64'(pend2_d), "R7 delayed data");
    if (wa && ra) begin
      chk(64'(wa && ra && !empty), 64'(1), "R9 both accepted");
    end
    pend2 = ra;
    pend2_d = exp_d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 2 + 1);
    // R2: state during reset
    chk(64'(empty), 64'(1), "R2 empty");
    chk(64'(full), 64'(0), "R2 full");
    chk(64'(almost_empty), 64'(1), "R2 almost_empty");
    chk(64'(almost_full), 64'(0), "R2 almost_full");
    chk(64'({wr_err, rd_err}), 64'(0), "R2 errors");
    chk(64'({wr_count, rd_count}), 64'(0), "R2 counts");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk across the almost-empty threshold
    foreach (VECS[i]) begin
      cyc(VECS[i][4], VECS[i][3]);
      chk(64'(empty), 64'(VECS[i][2]), "R5 table empty");
      chk(64'(almost_empty), 64'(VECS[i][1]), "R5 table almost_empty");
      chk(64'(rd_err), 64'(VECS[i][0]), "R4 table rd_err");
    end

    // fill to the depth, then overflow attempts
    while (occ < DEPTH) cyc(1'b1, 1'b0);
    chk(64'(full), 64'(1), "R1 full after depth writes");
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    chk(64'(wr_err), 64'(0), "R11 wr_err drops");
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);

    // drain, then underflow
    while (occ > 0) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    chk(64'(rd_err), 64'(0), "R11 rd_err drops");

    // mixed traffic, pointers wrap past the depth
    for (int i = 0; i < 1200; i++) cyc((i % 3) != 0, (i % 2) == 0);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1);
    while (occ > 0) cyc(1'b0, 1'b1);

    // asynchronous reset between edges
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0);
    wr_valid = 1'b0; rd_en = 1'b0;
    #(CLK_NS/4);
    rst_n = 1'b0;
    #1;
    chk(64'(empty), 64'(1), "R2 async empty");
    chk(64'(almost_empty), 64'(1), "R2 async almost_empty");
    chk(64'({full, almost_full}), 64'(0), "R2 async full flags");
    chk(64'({wr_count, rd_count}), 64'(0), "R2 async counts");
    chk(64'({rd_valid, rd_valid2}), 64'(0), "R2 async rd_valid");
    reset_model();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) cyc(1'b1, i > 2);
    while (occ > 0) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule